// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. It walks an ascending range of analog channels from a configured first channel to a configured last channel. It drives the channel-select lines and the trial code for an external DAC. It resolves one result bit per clock from a one-bit comparator input. Each finished conversion goes into a single shared 16-bit result word. That word is overwritten on every completion, so each completion also raises a request flag that DMA or an interrupt handler services and then acknowledges.

Three scan modes are available:
- **Single sweep:** converts the range once and then goes idle.
- **Continuous:** wraps from the last channel back to the first and repeats until software aborts the scan.
- **Paused-step:** converts one channel, then waits for a new start event before converting the next channel. It wraps at the end of the range.

A 2-bit source selector decides which event starts or resumes a scan: a software write of 1 to the busy control, a rising edge on an external trigger pin, a timer pulse, or either hardware trigger. Writing 0 to the busy control aborts the scan at once, even in the middle of a conversion.

The controller is a five-state machine:
- **IDLE** → **LAUNCH** on a start event.
- **LAUNCH** (issues the SAR go pulse) → **CONV**.
- **CONV** → **STEP** when the SAR reports end of conversion. The result is latched on this transition.
- **STEP** → **PAUSE** in paused-step mode.
- **STEP** → **IDLE** in single-sweep mode after the last channel.
- **STEP** → **LAUNCH** otherwise, with the channel advanced or wrapped.
- **PAUSE** → **LAUNCH** on a start event.
- Any state other than IDLE → **IDLE** on an abort write.

Top module: `adc_scan_seq`

## Requirements
- R1: The SAR resolves MSB first, one bit per clock. On each trial the bit is set and is then cleared if `cmp_hi` is 1, meaning the trial code is above the input. A 10-bit result therefore equals the input code for that channel.
- R2: With `cfg_res8`=1, the trial and the result are 8 bits, right-aligned in bits 7:0, and result bits 10:8 are zero.
- R3: The result word is {channel[4:0] in bits 15:11, a zero in bit 10, value in bits 9:0}. `done` is a one-cycle pulse in the same cycle the new result appears. The result does not change at any other time.
- R4: `cfg_mode`=00 (single sweep; 11 behaves the same) converts the first through the last channel once, in ascending order, then goes idle. When first equals last, exactly one conversion is done.
- R5: `cfg_mode`=01 (continuous) returns to the first channel after the last one and repeats. When first equals last, that channel is converted again and again.
- R6: A write of 0 to busy (`busy_wr`=1, `busy_wdata`=0) drops `busy` on the next cycle, even mid-conversion. No `done` follows, and the result keeps the last completed conversion.
- R7: `cfg_mode`=10 (paused-step) halts after each channel with `busy` still 1. It converts the next channel only on a new start event from the selected source, and wraps from the last channel to the first.
- R8: `cfg_trig_sel` selects the start source: 00 = software write of 1 to busy, 01 = rising edge of `ext_trig`, 10 = `tmr_trig` pulse, 11 = either hardware source. Sources that are not selected are ignored.
- R9: A start event that arrives while a channel is being launched or converted is ignored. Neither the channel order nor the number of conversions changes.
- R10: `conv_req` is set on every completion and stays set until `req_ack`. If a set and an acknowledge arrive in the same cycle, the set wins.
- R11: `busy` is 0 after reset and when idle, and 1 from the cycle after a start event until the scan ends or is aborted, including while paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Scan mode: 00 single, 01 continuous, 10 paused-step, 11 single |
| cfg_res8 | input | 1 | 1 selects 8-bit resolution, 0 selects 10-bit |
| cfg_trig_sel | input | 2 | Start source select |
| cfg_start_ch | input | 5 | First channel of the range |
| cfg_end_ch | input | 5 | Last channel of the range |
| busy_wr | input | 1 | Write strobe for the busy control |
| busy_wdata | input | 1 | Value written: 1 is a software start, 0 is an abort |
| ext_trig | input | 1 | External trigger pin, rising-edge active |
| tmr_trig | input | 1 | Timer trigger pulse |
| cmp_hi | input | 1 | Comparator: 1 when the trial code is above the analog input |
| req_ack | input | 1 | Clears the conversion request |
| ch_sel | output | 5 | Analog multiplexer channel select |
| dac_code | output | 10 | Right-aligned SAR trial code to the DAC |
| result | output | 16 | Shared result word |
| done | output | 1 | End-of-conversion pulse |
| busy | output | 1 | Scan in progress |
| conv_req | output | 1 | Pending request for DMA or interrupt service |

## Verification
The checker watches every cycle. It confirms that `done` lasts exactly one cycle and that the result word only moves on `done`. It also checks that the channel field matches `ch_sel` at completion, that the 8-bit format leaves bits 10:8 clear, and that an abort write always drops `busy` on the next cycle. The request flag is checked to be set on each completion and held until acknowledged, and `ch_sel` is checked to stay inside the configured range. Behaviour that depends on sequence and absence can only be shown by the directed scenarios against a comparator stub: the channel order and wrap, stopping after one sweep, pausing until the selected trigger arrives, and triggers that must be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W     = 5;
    localparam int RES_MAX  = 10;
    localparam int RES_LOW  = 8;
    localparam int RESULT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_CONV,
        ST_STEP,
        ST_PAUSE
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_CONT   = 2'b01,
        MODE_STEP   = 2'b10,
        MODE_SINGLE_ALT = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        SRC_SOFT   = 2'b00,
        SRC_EXT    = 2'b01,
        SRC_TIMER  = 2'b10,
        SRC_EITHER = 2'b11
    } trig_src_e;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       sw_start,
    input  logic       ext_pin,
    input  logic       tmr_pulse,
    output logic       start_evt
);

    logic ext_q;
    logic ext_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_pin;
        end
    end

    assign ext_rise = ext_pin & ~ext_q;

    always_comb begin
        unique case (trig_src_e'(sel))
            SRC_SOFT:   start_evt = sw_start;
            SRC_EXT:    start_evt = ext_rise;
            SRC_TIMER:  start_evt = tmr_pulse;
            SRC_EITHER: start_evt = ext_rise | tmr_pulse;
            default:    start_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_MAX = 10,
    parameter int RES_LOW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               abort,
    input  logic               res_low,
    input  logic               cmp_hi,
    output logic [RES_MAX-1:0] trial,
    output logic               eoc,
    output logic [RES_MAX-1:0] value
);

    localparam int IW = $clog2(RES_MAX);
    localparam logic [IW-1:0] MSB_HI = IW'(RES_MAX - 1);
    localparam logic [IW-1:0] MSB_LO = IW'(RES_LOW - 1);
    localparam logic [RES_MAX-1:0] ONE = RES_MAX'(1);

    logic [RES_MAX-1:0] sar_q;
    logic [RES_MAX-1:0] sar_nxt;
    logic [IW-1:0]      idx_q;
    logic               active_q;
    logic [IW-1:0]      msb;

    assign msb   = res_low ? MSB_LO : MSB_HI;
    assign trial = sar_q;

    // decide the current trial bit and arm the next lower one
    always_comb begin
        sar_nxt = sar_q;
        if (cmp_hi) begin
            sar_nxt[idx_q] = 1'b0;
        end
        if (idx_q != '0) begin
            sar_nxt[idx_q - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q    <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
            eoc      <= 1'b0;
            value    <= '0;
        end else begin
            eoc <= 1'b0;
            if (abort) begin
                active_q <= 1'b0;
                sar_q    <= '0;
            end else if (go) begin
                active_q <= 1'b1;
                sar_q    <= ONE << msb;
                idx_q    <= msb;
            end else if (active_q) begin
                sar_q <= sar_nxt;
                if (idx_q == '0) begin
                    active_q <= 1'b0;
                    eoc      <= 1'b1;
                    value    <= sar_nxt;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_chan_next.sv
module adc_chan_next #(
    parameter int CH_W = 5
) (
    input  logic [CH_W-1:0] cur,
    input  logic [CH_W-1:0] first,
    input  logic [CH_W-1:0] last,
    output logic            at_last,
    output logic [CH_W-1:0] nxt
);

    assign at_last = (cur == last);
    assign nxt     = at_last ? first : cur + 1'b1;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_res8,
    input  logic [1:0]          cfg_trig_sel,
    input  logic [CH_W-1:0]     cfg_start_ch,
    input  logic [CH_W-1:0]     cfg_end_ch,
    input  logic                busy_wr,
    input  logic                busy_wdata,
    input  logic                ext_trig,
    input  logic                tmr_trig,
    input  logic                cmp_hi,
    input  logic                req_ack,
    output logic [CH_W-1:0]     ch_sel,
    output logic [RES_MAX-1:0]  dac_code,
    output logic [RESULT_W-1:0] result,
    output logic                done,
    output logic                busy,
    output logic                conv_req
);

    localparam int PAD_W = RESULT_W - CH_W - RES_MAX;

    seq_state_e state_q, state_d;

    logic               sw_start;
    logic               abort;
    logic               start_evt;
    logic               sar_go;
    logic               sar_eoc;
    logic [RES_MAX-1:0] sar_value;
    logic [CH_W-1:0]    ch_q;
    logic [CH_W-1:0]    ch_nxt;
    logic               ch_at_last;
    scan_mode_e         mode;

    assign mode     = scan_mode_e'(cfg_mode);
    assign sw_start = busy_wr & busy_wdata;
    assign abort    = busy_wr & ~busy_wdata;

    adc_trig_sel u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (cfg_trig_sel),
        .sw_start  (sw_start),
        .ext_pin   (ext_trig),
        .tmr_pulse (tmr_trig),
        .start_evt (start_evt)
    );

    adc_sar_core #(
        .RES_MAX (RES_MAX),
        .RES_LOW (RES_LOW)
    ) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sar_go),
        .abort   (abort),
        .res_low (cfg_res8),
        .cmp_hi  (cmp_hi),
        .trial   (dac_code),
        .eoc     (sar_eoc),
        .value   (sar_value)
    );

    adc_chan_next #(
        .CH_W (CH_W)
    ) u_next (
        .cur     (ch_q),
        .first   (cfg_start_ch),
        .last    (cfg_end_ch),
        .at_last (ch_at_last),
        .nxt     (ch_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_CONV;
            end
            ST_CONV: begin
                if (sar_eoc) state_d = ST_STEP;
            end
            ST_STEP: begin
                if (mode == MODE_STEP) begin
                    state_d = ST_PAUSE;
                end else if (ch_at_last &&
                             (mode == MODE_SINGLE || mode == MODE_SINGLE_ALT)) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_PAUSE: begin
                if (start_evt) state_d = ST_LAUNCH;
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
        end
    end

    assign sar_go = (state_q == ST_LAUNCH) && !abort;
    assign busy   = (state_q != ST_IDLE);
    assign ch_sel = ch_q;

    // registered outputs: channel pointer, result word, done pulse, request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q     <= '0;
            result   <= '0;
            done     <= 1'b0;
            conv_req <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE && start_evt) begin
                ch_q <= cfg_start_ch;
            end
            if (state_q == ST_STEP && !abort) begin
                ch_q <= ch_nxt;
            end
            if (state_q == ST_CONV && sar_eoc && !abort) begin
                result   <= {ch_q, {PAD_W{1'b0}}, sar_value};
                done     <= 1'b1;
                conv_req <= 1'b1;
            end else if (req_ack) begin
                conv_req <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_res8,
    input logic [CH_W-1:0]     cfg_start_ch,
    input logic [CH_W-1:0]     cfg_end_ch,
    input logic                busy_wr,
    input logic                busy_wdata,
    input logic                req_ack,
    input logic [CH_W-1:0]     ch_sel,
    input logic [RESULT_W-1:0] result,
    input logic                done,
    input logic                busy,
    input logic                conv_req
);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R3
    result_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[15:11] == ch_sel && result[10] == 1'b0));

    // R2
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_res8) |-> (result[10:8] == 3'b000));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_wr && !busy_wdata) |=> !busy);

    // R10
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> conv_req);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !req_ack) |=> conv_req);

    // R4
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_start_ch <= cfg_end_ch) |->
            (ch_sel >= cfg_start_ch && ch_sel <= cfg_end_ch));

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_res8     (cfg_res8),
    .cfg_start_ch (cfg_start_ch),
    .cfg_end_ch   (cfg_end_ch),
    .busy_wr      (busy_wr),
    .busy_wdata   (busy_wdata),
    .req_ack      (req_ack),
    .ch_sel       (ch_sel),
    .result       (result),
    .done         (done),
    .busy         (busy),
    .conv_req     (conv_req)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_res8 = 1'b0;
    logic [1:0]  cfg_trig_sel = 2'b00;
    logic [4:0]  cfg_start_ch = 5'd0;
    logic [4:0]  cfg_end_ch = 5'd0;
    logic        busy_wr = 1'b0;
    logic        busy_wdata = 1'b0;
    logic        ext_trig = 1'b0;
    logic        tmr_trig = 1'b0;
    logic        cmp_hi;
    logic        req_ack = 1'b0;
    logic [4:0]  ch_sel;
    logic [9:0]  dac_code;
    logic [15:0] result;
    logic        done;
    logic        busy;
    logic        conv_req;

    int n_checks = 0;
    int n_errors = 0;
    int n_cap = 0;
    logic [15:0] cap [64];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_scan_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_res8     (cfg_res8),
        .cfg_trig_sel (cfg_trig_sel),
        .cfg_start_ch (cfg_start_ch),
        .cfg_end_ch   (cfg_end_ch),
        .busy_wr      (busy_wr),
        .busy_wdata   (busy_wdata),
        .ext_trig     (ext_trig),
        .tmr_trig     (tmr_trig),
        .cmp_hi       (cmp_hi),
        .req_ack      (req_ack),
        .ch_sel       (ch_sel),
        .dac_code     (dac_code),
        .result       (result),
        .done         (done),
        .busy         (busy),
        .conv_req     (conv_req)
    );

    function automatic int code_of(int ch, bit r8);
        return r8 ? (ch * 29 + 3) % 256 : (ch * 37 + 5) % 1024;
    endfunction

    function automatic logic [15:0] exp_res(int ch, bit r8);
        logic [9:0] v;
        logic [4:0] c;
        v = 10'(code_of(ch, r8));
        c = 5'(ch);
        return {c, 1'b0, v};
    endfunction

    // analog stub: comparator against a fixed code per channel
    always_comb begin
        cmp_hi = (int'(dac_code) > code_of(int'(ch_sel), cfg_res8));
    end

    // capture every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (n_cap < 64) cap[n_cap] = result;
            n_cap = n_cap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic busy_write(input bit v);
        @(negedge clk);
        busy_wr = 1'b1;
        busy_wdata = v;
        @(negedge clk);
        busy_wr = 1'b0;
        busy_wdata = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic tmr_pulse();
        @(negedge clk);
        tmr_trig = 1'b1;
        @(negedge clk);
        tmr_trig = 1'b0;
    endtask

    task automatic wait_caps(input int n, input int limit);
        for (int i = 0; i < limit && n_cap < n; i++) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input bit r8, input logic [1:0] ts,
                         input int first, input int last);
        @(negedge clk);
        cfg_mode = m;
        cfg_res8 = r8;
        cfg_trig_sel = ts;
        cfg_start_ch = 5'(first);
        cfg_end_ch = 5'(last);
        n_cap = 0;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R11 reset busy", busy, 0);
        chk(done == 1'b0, "R3 reset done", done, 0);
        chk(result == 16'h0, "R3 reset result", result, 0);
        chk(conv_req == 1'b0, "R10 reset req", conv_req, 0);
    endtask

    task automatic t_single_sweep();
        setup(2'b00, 1'b0, 2'b00, 2, 5);
        busy_write(1'b1);
        chk(busy == 1'b1, "R11 busy after start", busy, 1);
        wait_caps(4, 400);
        cycles(40);
        chk(n_cap == 4, "R4 sweep count", n_cap, 4);
        for (int i = 0; i < 4; i++)
            chk(cap[i] == exp_res(2 + i, 1'b0), "R1 R3 R4 sweep value", cap[i], exp_res(2 + i, 1'b0));
        chk(busy == 1'b0, "R4 R11 idle after sweep", busy, 0);
    endtask

    task automatic t_single_one();
        setup(2'b11, 1'b0, 2'b00, 7, 7);
        busy_write(1'b1);
        wait_caps(1, 200);
        cycles(60);
        chk(n_cap == 1, "R4 single channel count", n_cap, 1);
        chk(cap[0] == exp_res(7, 1'b0), "R4 single channel value", cap[0], exp_res(7, 1'b0));
        chk(busy == 1'b0, "R4 idle after one", busy, 0);
    endtask

    task automatic t_narrow();
        setup(2'b00, 1'b1, 2'b00, 0, 1);
        busy_write(1'b1);
        wait_caps(2, 300);
        cycles(20);
        chk(n_cap == 2, "R2 narrow count", n_cap, 2);
        for (int i = 0; i < 2; i++)
            chk(cap[i] == exp_res(i, 1'b1), "R2 narrow value", cap[i], exp_res(i, 1'b1));
    endtask

    task automatic t_cont_abort();
        logic [15:0] saved;
        int held;
        setup(2'b01, 1'b0, 2'b00, 30, 31);
        busy_write(1'b1);
        wait_caps(5, 600);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == exp_res((i % 2 == 0) ? 30 : 31, 1'b0), "R5 wrap order",
                cap[i], exp_res((i % 2 == 0) ? 30 : 31, 1'b0));
        cycles(5);
        saved = result;
        held = n_cap;
        busy_write(1'b0);
        chk(busy == 1'b0, "R6 busy drops", busy, 0);
        cycles(60);
        chk(n_cap == held, "R6 no done after abort", n_cap, held);
        chk(result == saved, "R6 result kept", result, saved);
    endtask

    task automatic t_cont_same();
        setup(2'b01, 1'b0, 2'b00, 4, 4);
        busy_write(1'b1);
        wait_caps(3, 400);
        chk(n_cap >= 3, "R5 repeat count", n_cap, 3);
        for (int i = 0; i < 3; i++)
            chk(cap[i] == exp_res(4, 1'b0), "R5 repeat value", cap[i], exp_res(4, 1'b0));
        busy_write(1'b0);
        cycles(2);
    endtask

    task automatic t_step_ext();
        setup(2'b10, 1'b0, 2'b01, 1, 2);
        busy_write(1'b1);
        cycles(40);
        chk(busy == 1'b0 && n_cap == 0, "R8 soft start ignored when ext selected", n_cap, 0);
        ext_pulse();
        wait_caps(1, 200);
        cycles(40);
        chk(n_cap == 1, "R7 paused after first", n_cap, 1);
        chk(busy == 1'b1, "R7 R11 busy while paused", busy, 1);
        busy_write(1'b1);
        tmr_pulse();
        cycles(40);
        chk(n_cap == 1, "R7 R8 unselected sources ignored in pause", n_cap, 1);
        ext_pulse();
        wait_caps(2, 200);
        ext_pulse();
        wait_caps(3, 200);
        chk(n_cap == 3, "R7 resumed count", n_cap, 3);
        chk(cap[0] == exp_res(1, 1'b0), "R7 first", cap[0], exp_res(1, 1'b0));
        chk(cap[1] == exp_res(2, 1'b0), "R7 second", cap[1], exp_res(2, 1'b0));
        chk(cap[2] == exp_res(1, 1'b0), "R7 wrap", cap[2], exp_res(1, 1'b0));
        busy_write(1'b0);
        cycles(2);
    endtask

    task automatic t_timer_src();
        setup(2'b00, 1'b0, 2'b10, 9, 9);
        ext_pulse();
        cycles(30);
        chk(n_cap == 0 && busy == 1'b0, "R8 ext ignored with timer select", n_cap, 0);
        tmr_pulse();
        wait_caps(1, 200);
        chk(n_cap == 1 && cap[0] == exp_res(9, 1'b0), "R8 timer start", cap[0], exp_res(9, 1'b0));
        cycles(10);
        setup(2'b00, 1'b0, 2'b11, 12, 12);
        ext_pulse();
        wait_caps(1, 200);
        chk(n_cap == 1 && cap[0] == exp_res(12, 1'b0), "R8 either select via ext", cap[0], exp_res(12, 1'b0));
        cycles(10);
    endtask

    task automatic t_ignore_restart();
        setup(2'b00, 1'b0, 2'b00, 3, 4);
        busy_write(1'b1);
        cycles(4);
        busy_write(1'b1);
        wait_caps(2, 400);
        cycles(60);
        chk(n_cap == 2, "R9 count unchanged by restart", n_cap, 2);
        chk(cap[0] == exp_res(3, 1'b0) && cap[1] == exp_res(4, 1'b0), "R9 order unchanged",
            cap[1], exp_res(4, 1'b0));
    endtask

    task automatic t_request();
        chk(conv_req == 1'b1, "R10 request pending", conv_req, 1);
        cycles(10);
        chk(conv_req == 1'b1, "R10 request held", conv_req, 1);
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        chk(conv_req == 1'b0, "R10 request cleared", conv_req, 0);
    endtask

    initial begin
        cycles(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_single_sweep();
        t_request();
        t_single_one();
        t_narrow();
        t_cont_abort();
        t_cont_same();
        t_step_ext();
        t_timer_src();
        t_ignore_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule